// File: doc/BRIEF.md
# Fault and Status Interrupt Aggregator

This block gathers a set of fault and status event lines into one interrupt pin. Each source has three bits: a live bit that mirrors the event while the device is running, a sticky latched bit that records that the event happened, and a mask bit that decides whether the latched bit may raise the interrupt. Software uses a small register port to read the live and latched views, to change the masks, and to set the pin behaviour. Reading the latched view also clears it.

The event inputs are sampled on every clock. The current operating mode qualifies them: live bits hold data only in the running mode and are zeroed in shutdown. The thermal warning sources are ignored in the idle and noise-gate modes. The pin is modelled as an open-drain driver. One output says when the driver pulls the pad low. A second output gives the pad level that results when an external pull-up is assumed. A control field selects a level output, a one-cycle pulse output, or no output. A polarity bit flips the asserted level.

Top module: `irq_aggregator`

## Requirements
- R1: After reset all live and latched bits read 0. The mask register reads 0x1F, which masks the thermal warnings (sources 0 to 3) and the clock error (source 4) and leaves sources 5 to 7 unmasked. The control register reads 0 and the pad is released (`irq_pull_o` = 0).
- R2: In the running mode (`mode_i` = 0), the live register (address 0) shows the event inputs one clock after they are sampled. In shutdown (`mode_i` = 3), every live bit reads 0 from the next clock onward.
- R3: In idle (`mode_i` = 1) or noise-gate (`mode_i` = 2) mode, an event on sources 0 to 3 sets neither the live bit nor the latched bit of that source.
- R4: A latched bit (address 1) stays set after its event goes away and while the device is in shutdown. It is only cleared as described in R5 and R7.
- R5: A read of address 1 returns the latched bits as they were before the read, and clears them at the next clock edge.
- R6: If an event sets a latched bit in the same cycle that a read clears it, the bit stays set.
- R7: Writing control (address 3) with bit 3 = 1 clears all latched bits. Bit 3 always reads back as 0.
- R8: In level mode (control bits [1:0] = 00) with polarity 0, `irq_pull_o` is 1 exactly when some latched bit has its mask bit at 0.
- R9: With control bit 2 = 1, the polarity is inverted. `irq_pull_o` then carries the complement of the asserted state, and `irq_pin_o` is always the inverse of `irq_pull_o`.
- R10: In pulse mode (control bits [1:0] = 01), a latched bit that goes from 0 to 1 while its source is unmasked asserts the pin for exactly one cycle, in the cycle after the event is sampled. An event on a bit that is already latched produces no pulse.
- R11: Control bits [1:0] = 10 (disabled) or 11 (reserved) hold the pin in its non-asserted state.
- R12: The mask register (address 2) can be written and reads back the written value. A mask bit of 1 blocks its source from the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Operating mode: 0 running, 1 idle, 2 noise gate, 3 shutdown |
| evt_i | input | N | Event lines, one per source, sampled every clock |
| reg_re_i | input | 1 | Register read strobe |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 live, 1 latched, 2 mask, 3 control |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Read data, valid in the cycle `reg_re_i` is high, 0 otherwise |
| irq_pull_o | output | 1 | 1 when the open-drain driver pulls the pad low |
| irq_pin_o | output | 1 | Pad level, assuming an external pull-up |

## Verification
A latched bit that is lost shows up twice: the next read of address 1 returns 0 where a 1 is expected, and in level mode the pad releases in the very next cycle. A wrong mask or gating decision changes `irq_pull_o` one clock after the event is sampled. A stale pulse register shows up as a second pulse cycle. The directed scenarios therefore compare the pad on the cycle right after each event and each register write. They also read the register views back, to find state the pad cannot reveal because it is masked.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_IDLE  = 2'd1,
        MODE_NGATE = 2'd2,
        MODE_SHUT  = 2'd3
    } op_mode_e;

    typedef enum logic [1:0] {
        PIN_LEVEL = 2'd0,
        PIN_PULSE = 2'd1,
        PIN_OFF   = 2'd2,
        PIN_RSVD  = 2'd3
    } pin_cfg_e;

    localparam logic [1:0] ADDR_LIVE  = 2'd0;
    localparam logic [1:0] ADDR_LATCH = 2'd1;
    localparam logic [1:0] ADDR_MASK  = 2'd2;
    localparam logic [1:0] ADDR_CTRL  = 2'd3;

    localparam int CTRL_POL_BIT = 2;
    localparam int CTRL_CLR_BIT = 3;

endpackage

// File: rtl/irq_src_qual.sv
module irq_src_qual
    import irq_agg_pkg::*;
#(
    parameter int          N        = 8,
    parameter logic [N-1:0] THERM_SRC = 8'h0F
) (
    input  logic [1:0]   mode_i,
    input  logic [N-1:0] evt_i,
    output logic [N-1:0] latch_set_o,
    output logic [N-1:0] live_set_o
);

    logic quiet_mode;
    logic run_mode;

    assign quiet_mode = (mode_i == MODE_IDLE) || (mode_i == MODE_NGATE);
    assign run_mode   = (mode_i == MODE_RUN);

    for (genvar i = 0; i < N; i++) begin : g_src
        if (THERM_SRC[i]) begin : g_therm
            assign latch_set_o[i] = evt_i[i] & ~quiet_mode;
        end else begin : g_plain
            assign latch_set_o[i] = evt_i[i];
        end
        assign live_set_o[i] = latch_set_o[i] & run_mode;
    end

endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv
    import irq_agg_pkg::*;
(
    input  logic       level_i,
    input  logic       pulse_i,
    input  logic [1:0] cfg_i,
    input  logic       pol_i,
    output logic       pull_o,
    output logic       pin_o
);

    logic asserted;

    always_comb begin
        case (cfg_i)
            PIN_LEVEL: asserted = level_i;
            PIN_PULSE: asserted = pulse_i;
            default:   asserted = 1'b0;
        endcase
    end

    // active low: pull when asserted; active high: pull when idle
    assign pull_o = asserted ^ pol_i;
    assign pin_o  = ~pull_o;

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int           N         = 8,
    parameter int           DW        = 8,
    parameter logic [N-1:0] THERM_SRC = 8'h0F,
    parameter logic [N-1:0] MASK_RST  = 8'h1F
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [1:0]    mode_i,
    input  logic [N-1:0]  evt_i,
    input  logic          reg_re_i,
    input  logic          reg_we_i,
    input  logic [1:0]    reg_addr_i,
    input  logic [DW-1:0] reg_wdata_i,
    output logic [DW-1:0] reg_rdata_o,
    output logic          irq_pull_o,
    output logic          irq_pin_o
);

    localparam int CFG_W = 2;

    typedef struct packed {
        logic [N-1:0]     live;
        logic [N-1:0]     latch;
        logic [N-1:0]     mask;
        logic [CFG_W-1:0] cfg;
        logic             pol;
        logic             pulse;
    } state_t;

    state_t st_d, st_q;

    logic [N-1:0] latch_set;
    logic [N-1:0] live_set;
    logic         rd_clear;
    logic         wr_clear;

    logic [N-1:0]     live_q;
    logic [N-1:0]     latch_q;
    logic [N-1:0]     mask_q;
    logic [CFG_W-1:0] cfg_q;
    logic             pol_q;

    assign live_q  = st_q.live;
    assign latch_q = st_q.latch;
    assign mask_q  = st_q.mask;
    assign cfg_q   = st_q.cfg;
    assign pol_q   = st_q.pol;

    irq_src_qual #(
        .N        (N),
        .THERM_SRC(THERM_SRC)
    ) u_qual (
        .mode_i     (mode_i),
        .evt_i      (evt_i),
        .latch_set_o(latch_set),
        .live_set_o (live_set)
    );

    assign rd_clear = reg_re_i && (reg_addr_i == ADDR_LATCH);
    assign wr_clear = reg_we_i && (reg_addr_i == ADDR_CTRL) && reg_wdata_i[CTRL_CLR_BIT];

    always_comb begin
        st_d       = st_q;
        st_d.live  = live_set;
        // a set in the clearing cycle survives
        st_d.latch = ((rd_clear || wr_clear) ? '0 : st_q.latch) | latch_set;
        st_d.pulse = |(latch_set & ~st_q.latch & ~st_q.mask);
        if (reg_we_i) begin
            case (reg_addr_i)
                ADDR_MASK: st_d.mask = reg_wdata_i[N-1:0];
                ADDR_CTRL: begin
                    st_d.cfg = reg_wdata_i[CFG_W-1:0];
                    st_d.pol = reg_wdata_i[CTRL_POL_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q       <= '0;
            st_q.mask  <= MASK_RST;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        if (reg_re_i) begin
            case (reg_addr_i)
                ADDR_LIVE:  reg_rdata_o[N-1:0] = st_q.live;
                ADDR_LATCH: reg_rdata_o[N-1:0] = st_q.latch;
                ADDR_MASK:  reg_rdata_o[N-1:0] = st_q.mask;
                default: begin
                    reg_rdata_o[CFG_W-1:0]    = st_q.cfg;
                    reg_rdata_o[CTRL_POL_BIT] = st_q.pol;
                end
            endcase
        end
    end

    irq_pin_drv u_pin (
        .level_i(|(st_q.latch & ~st_q.mask)),
        .pulse_i(st_q.pulse),
        .cfg_i  (st_q.cfg),
        .pol_i  (st_q.pol),
        .pull_o (irq_pull_o),
        .pin_o  (irq_pin_o)
    );

endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
    import irq_agg_pkg::*;
#(
    parameter int           N         = 8,
    parameter int           DW        = 8,
    parameter logic [N-1:0] THERM_SRC = 8'h0F
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic [1:0]    mode_i,
    input logic [N-1:0]  evt_i,
    input logic          reg_re_i,
    input logic          reg_we_i,
    input logic [1:0]    reg_addr_i,
    input logic [DW-1:0] reg_wdata_i,
    input logic [N-1:0]  live_q,
    input logic [N-1:0]  latch_q,
    input logic [N-1:0]  mask_q,
    input logic [1:0]    cfg_q,
    input logic          pol_q,
    input logic          irq_pull_o,
    input logic          irq_pin_o
);

    logic clr_req;
    assign clr_req = (reg_re_i && reg_addr_i == ADDR_LATCH) ||
                     (reg_we_i && reg_addr_i == ADDR_CTRL && reg_wdata_i[CTRL_CLR_BIT]);

    p_shut_live_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == MODE_SHUT) |=> (live_q == '0));

    p_therm_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == MODE_IDLE || mode_i == MODE_NGATE)
            |=> ((latch_q & THERM_SRC & ~$past(latch_q)) == '0));

    p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_req |=> ((latch_q & $past(latch_q)) == $past(latch_q)));

    p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((latch_q & $past(evt_i & ~THERM_SRC)) == $past(evt_i & ~THERM_SRC)));

    p_level_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_q == PIN_LEVEL) |-> ((irq_pull_o ^ pol_q) == (|(latch_q & ~mask_q))));

    p_pin_inv_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_pin_o != irq_pull_o);

    p_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_q[1] |-> (irq_pull_o == pol_q));

endmodule

bind irq_aggregator irq_aggregator_chk #(
    .N        (N),
    .DW       (DW),
    .THERM_SRC(THERM_SRC)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_i),
    .evt_i      (evt_i),
    .reg_re_i   (reg_re_i),
    .reg_we_i   (reg_we_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .live_q     (live_q),
    .latch_q    (latch_q),
    .mask_q     (mask_q),
    .cfg_q      (cfg_q),
    .pol_q      (pol_q),
    .irq_pull_o (irq_pull_o),
    .irq_pin_o  (irq_pin_o)
);

// File: tb/irq_aggregator_tb_top.sv
module irq_aggregator_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [7:0] evt = '0;
    logic       re = 1'b0;
    logic       we = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       pull;
    logic       pin;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_aggregator dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .mode_i     (mode),
        .evt_i      (evt),
        .reg_re_i   (re),
        .reg_we_i   (we),
        .reg_addr_i (addr),
        .reg_wdata_i(wdata),
        .reg_rdata_o(rdata),
        .irq_pull_o (pull),
        .irq_pin_o  (pin)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        re = 1'b1;
        addr = a;
        #1;
        d = rdata;
        step();
        re = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        we = 1'b1;
        addr = a;
        wdata = d;
        step();
        we = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 pad", {7'd0, pull}, 8'h00);
        chk("R9 pin inverse", {7'd0, pin}, 8'h01);
        rd(2'd0, d); chk("R1 live", d, 8'h00);
        rd(2'd1, d); chk("R1 latched", d, 8'h00);
        rd(2'd2, d); chk("R1 mask", d, 8'h1F);
        rd(2'd3, d); chk("R1 ctrl", d, 8'h00);
    endtask

    task automatic t_live_sticky();
        logic [7:0] d;
        mode = 2'd0;
        evt = 8'h20;
        step();
        chk("R8 unmasked level", {7'd0, pull}, 8'h01);
        rd(2'd0, d); chk("R2 live run", d, 8'h20);
        mode = 2'd3;
        step();
        rd(2'd0, d); chk("R2 live shutdown", d, 8'h00);
        evt = 8'h00;
        step();
        rd(2'd1, d); chk("R4 latched kept", d, 8'h20);
        rd(2'd1, d); chk("R5 read cleared", d, 8'h00);
        chk("R8 released", {7'd0, pull}, 8'h00);
        mode = 2'd0;
    endtask

    task automatic t_thermal();
        logic [7:0] d;
        mode = 2'd1;
        evt = 8'h01;
        step();
        mode = 2'd2;
        evt = 8'h02;
        step();
        evt = 8'h00;
        rd(2'd1, d); chk("R3 quiet modes", d, 8'h00);
        mode = 2'd0;
        evt = 8'h01;
        step();
        evt = 8'h00;
        chk("R8 masked source", {7'd0, pull}, 8'h00);
        wr(2'd2, 8'h00);
        chk("R12 unmask raises pad", {7'd0, pull}, 8'h01);
        rd(2'd2, d); chk("R12 mask readback", d, 8'h00);
        wr(2'd3, 8'h08);
        chk("R7 clear releases pad", {7'd0, pull}, 8'h00);
        rd(2'd1, d); chk("R7 latched empty", d, 8'h00);
        rd(2'd3, d); chk("R7 clear bit reads 0", d, 8'h00);
        wr(2'd2, 8'h1F);
    endtask

    task automatic t_set_wins();
        logic [7:0] d;
        evt = 8'h40;
        step();
        rd(2'd1, d); chk("R6 first read", d, 8'h40);
        rd(2'd1, d); chk("R6 set beats clear", d, 8'h40);
        evt = 8'h00;
        rd(2'd1, d); chk("R6 last set", d, 8'h40);
        rd(2'd1, d); chk("R5 cleared", d, 8'h00);
    endtask

    task automatic t_polarity();
        evt = 8'h80;
        step();
        evt = 8'h00;
        chk("R8 pad pulled", {7'd0, pull}, 8'h01);
        wr(2'd3, 8'h04);
        chk("R9 inverted asserted", {7'd0, pull}, 8'h00);
        chk("R9 pin high", {7'd0, pin}, 8'h01);
        wr(2'd3, 8'h0C);
        chk("R9 inverted idle", {7'd0, pull}, 8'h01);
        wr(2'd3, 8'h00);
    endtask

    task automatic t_pulse();
        wr(2'd3, 8'h01);
        evt = 8'h80;
        step();
        chk("R10 pulse on", {7'd0, pull}, 8'h01);
        step();
        chk("R10 pulse one cycle", {7'd0, pull}, 8'h00);
        evt = 8'h00;
        step();
        evt = 8'h80;
        step();
        evt = 8'h00;
        chk("R10 no pulse on latched bit", {7'd0, pull}, 8'h00);
        wr(2'd3, 8'h09);
    endtask

    task automatic t_disabled();
        wr(2'd3, 8'h02);
        evt = 8'h20;
        step();
        chk("R11 disabled", {7'd0, pull}, 8'h00);
        wr(2'd3, 8'h03);
        chk("R11 reserved", {7'd0, pull}, 8'h00);
        wr(2'd3, 8'h06);
        chk("R11 disabled inverted", {7'd0, pull}, 8'h01);
        evt = 8'h00;
        wr(2'd3, 8'h08);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
        t_reset();
        t_live_sticky();
        t_thermal();
        t_set_wins();
        t_polarity();
        t_pulse();
        t_disabled();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule